// File: doc/BRIEF.md
# Banked System Handler State Register

This block keeps the active, pending and enable flags of the core's system exception handlers. It presents them through one 32-bit word on a simple register bus. Each access carries a Secure attribute. That attribute picks which of two copies of the banked flags is seen, and it also decides whether the Secure-only and routing-dependent flags are visible at all. Exception hardware sets and clears individual flags through per-bit strobes, and the whole flag vector is driven out to the interrupt prioritisation logic.

A configuration input hands bus faults, hard faults and NMI over to the Non-secure world, and it widens what a Non-secure access may see and change. A second input gives the CPU's current security state, which matters for one clear-only path. A parameter selects a legacy profile with no security extension, in which the Non-secure view loses its hard-fault flags. Every register write raises a one-cycle strobe so that downstream logic re-evaluates.

Top module: `shs_bank_reg`

## Requirements
- R1: After reset every state bit, the read data and the change strobe are zero.
- R2: The flag vector `hstate` holds a Non-secure copy in bits 0..11 and a Secure copy in bits 12..23, indexed k = 0..11. The flags map to register bits as follows: MemManage active 0, HardFault active 2, UsageFault active 3, SVCall active 7, PendSV active 10, SysTick active 11, UsageFault pending 12, MemManage pending 13, SVCall pending 15, HardFault pending 21, MemManage enable 16, UsageFault enable 18. A Secure access reads and writes the Secure copy and a Non-secure access reads and writes the Non-secure copy, with the exceptions in R6–R8.
- R3: SecureFault active, pending and enable (`hstate` 27, 28, 29; register bits 4, 20, 19) have one copy. Secure accesses read and write it. Non-secure accesses read zero and their writes do not change it.
- R4: BusFault active, pending and enable (`hstate` 24, 25, 26; register bits 1, 14, 17) have one copy. It is read and written only when the access is Secure or `route_ns` is 1. Otherwise it reads zero and ignores writes.
- R5: NMI active (`hstate` 30, register bit 5) reads as its state only when LEGACY is 0 and the access is Secure or `route_ns` is 1. Otherwise it reads zero.
- R6: A Secure write never changes the Secure HardFault active flag (`hstate` 13).
- R7: A write clears NMI active and the Non-secure HardFault active flag (`hstate` 1) only when four conditions all hold: the access is Non-secure, `cpu_sec` is 1, `route_ns` is 1, and the written bit (5 or 2) is 0. No register write ever sets either flag.
- R8: With LEGACY = 1, a Non-secure read returns zero in bits 2 and 21, and a Non-secure write leaves the Non-secure HardFault pending flag (`hstate` 9) unchanged.
- R9: DebugMonitor active (`hstate` 31, register bit 8) has one copy that both security states read and write.
- R10: `state_chg` is 1 in the cycle after each write to the register offset, and 0 after any other cycle.
- R11: Reserved bits 6, 9 and 22–31 read zero. A read of any other offset returns zero, and a write to any other offset changes no state.
- R12: `hw_set` and `hw_clr` override a register write to the same bit in the same cycle. When both strobe one bit, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Access offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sec | input | 1 | Access is Secure |
| bus_rdata | output | 32 | Read data (combinational, zero when not reading the register) |
| cpu_sec | input | 1 | CPU currently in Secure state |
| route_ns | input | 1 | Bus, hard and NMI faults routed to Non-secure |
| hw_set | input | 32 | Per-flag set strobes, indexed as `hstate` |
| hw_clr | input | 32 | Per-flag clear strobes, indexed as `hstate` |
| hstate | output | 32 | Current flag vector |
| state_chg | output | 1 | One-cycle pulse after a register write |

## Verification
The bench attacks the clear-only path for NMI and Non-secure HardFault active by removing each of the four conditions in turn. A design that decoded the condition loosely would drop those flags on an ordinary Non-secure write, or would let a written 1 set them. It also writes all ones from each side with `route_ns` low and high. A design with a wrong bank select would then leak SecureFault or BusFault state into the Non-secure view, or take a Non-secure write into the Secure copy. A second instance built with LEGACY set runs the same traffic, so that a design missing the legacy masking reports hard-fault state to Non-secure reads or takes the pending write. Writes that collide with hardware strobes, and writes to a neighbouring offset, show whether precedence and address decoding are wrong.

// File: rtl/shs_pkg.sv
package shs_pkg;

    localparam int REG_W    = 32;
    localparam int NBANK    = 12;
    localparam int NSHARED  = 8;
    localparam int NSTATE   = 2 * NBANK + NSHARED;
    localparam int SEC_BASE = NBANK;
    localparam int SH_BASE  = 2 * NBANK;

    // banked flag indices inside one copy
    localparam int BK_HF_ACT  = 1;
    localparam int BK_HF_PEND = 9;

    // shared flag indices in the full state vector
    localparam int SH_NMI_ACT = SH_BASE + 6;

    // access classes of shared flags
    typedef enum logic [1:0] {
        ACC_ANY    = 2'd0,
        ACC_SEC    = 2'd1,
        ACC_ROUTED = 2'd2,
        ACC_NMI    = 2'd3
    } acc_class_e;

    typedef struct packed {
        logic [NSTATE-1:0] st;
        logic              chg;
    } shs_reg_t;

    function automatic logic [4:0] bank_pos(input int k);
        case (k)
            0:       return 5'd0;
            1:       return 5'd2;
            2:       return 5'd3;
            3:       return 5'd7;
            4:       return 5'd10;
            5:       return 5'd11;
            6:       return 5'd12;
            7:       return 5'd13;
            8:       return 5'd15;
            9:       return 5'd21;
            10:      return 5'd16;
            default: return 5'd18;
        endcase
    endfunction

    function automatic logic [4:0] shared_pos(input int j);
        case (j)
            0:       return 5'd1;
            1:       return 5'd14;
            2:       return 5'd17;
            3:       return 5'd4;
            4:       return 5'd20;
            5:       return 5'd19;
            6:       return 5'd5;
            default: return 5'd8;
        endcase
    endfunction

    function automatic acc_class_e shared_class(input int j);
        case (j)
            0, 1, 2: return ACC_ROUTED;
            3, 4, 5: return ACC_SEC;
            6:       return ACC_NMI;
            default: return ACC_ANY;
        endcase
    endfunction

endpackage

// File: rtl/shs_read_view.sv
module shs_read_view
    import shs_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic [NSTATE-1:0] st,
    input  logic              acc_sec,
    input  logic              route_ns,
    output logic [REG_W-1:0]  view
);

    logic open_routed;

    always_comb begin
        open_routed = acc_sec | route_ns;
        view        = '0;
        for (int k = 0; k < NBANK; k++) begin
            if (acc_sec) begin
                view[bank_pos(k)] = st[SEC_BASE + k];
            end else if (LEGACY && (k == BK_HF_ACT || k == BK_HF_PEND)) begin
                view[bank_pos(k)] = 1'b0;
            end else begin
                view[bank_pos(k)] = st[k];
            end
        end
        for (int j = 0; j < NSHARED; j++) begin
            case (shared_class(j))
                ACC_ANY:    view[shared_pos(j)] = st[SH_BASE + j];
                ACC_SEC:    view[shared_pos(j)] = acc_sec & st[SH_BASE + j];
                ACC_ROUTED: view[shared_pos(j)] = open_routed & st[SH_BASE + j];
                default:    view[shared_pos(j)] = !LEGACY & open_routed & st[SH_BASE + j];
            endcase
        end
    end

endmodule

// File: rtl/shs_write_plan.sv
module shs_write_plan
    import shs_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic              wr_hit,
    input  logic              acc_sec,
    input  logic              route_ns,
    input  logic              cpu_sec,
    input  logic [REG_W-1:0]  wdata,
    output logic [NSTATE-1:0] load_mask,
    output logic [NSTATE-1:0] load_val,
    output logic [NSTATE-1:0] clr_mask
);

    logic ns_clear_ok;

    always_comb begin
        load_mask   = '0;
        load_val    = '0;
        clr_mask    = '0;
        ns_clear_ok = wr_hit & !acc_sec & cpu_sec & route_ns;

        for (int k = 0; k < NBANK; k++) begin
            load_val[k]            = wdata[bank_pos(k)];
            load_val[SEC_BASE + k] = wdata[bank_pos(k)];
            if (k != BK_HF_ACT) begin
                load_mask[SEC_BASE + k] = wr_hit & acc_sec;
                if (!(LEGACY && k == BK_HF_PEND)) begin
                    load_mask[k] = wr_hit & !acc_sec;
                end
            end
        end

        for (int j = 0; j < NSHARED; j++) begin
            load_val[SH_BASE + j] = wdata[shared_pos(j)];
            case (shared_class(j))
                ACC_ANY:    load_mask[SH_BASE + j] = wr_hit;
                ACC_SEC:    load_mask[SH_BASE + j] = wr_hit & acc_sec;
                ACC_ROUTED: load_mask[SH_BASE + j] = wr_hit & (acc_sec | route_ns);
                default:    load_mask[SH_BASE + j] = 1'b0;
            endcase
        end

        clr_mask[SH_NMI_ACT] = ns_clear_ok & !wdata[shared_pos(SH_NMI_ACT - SH_BASE)];
        clr_mask[BK_HF_ACT]  = ns_clear_ok & !wdata[bank_pos(BK_HF_ACT)];
    end

endmodule

// File: rtl/shs_bank_reg.sv
module shs_bank_reg
    import shs_pkg::*;
#(
    parameter int              ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFS = 'hD24,
    parameter bit              LEGACY  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_sec,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               cpu_sec,
    input  logic               route_ns,
    input  logic [NSTATE-1:0]  hw_set,
    input  logic [NSTATE-1:0]  hw_clr,
    output logic [NSTATE-1:0]  hstate,
    output logic               state_chg
);

    shs_reg_t          r_d, r_q;
    logic              hit;
    logic              wr_hit;
    logic [REG_W-1:0]  view;
    logic [NSTATE-1:0] load_mask, load_val, clr_mask;

    assign hit    = (bus_addr == REG_OFS);
    assign wr_hit = bus_wr & hit;

    shs_read_view #(.LEGACY(LEGACY)) u_view (
        .st       (r_q.st),
        .acc_sec  (bus_sec),
        .route_ns (route_ns),
        .view     (view)
    );

    shs_write_plan #(.LEGACY(LEGACY)) u_plan (
        .wr_hit    (wr_hit),
        .acc_sec   (bus_sec),
        .route_ns  (route_ns),
        .cpu_sec   (cpu_sec),
        .wdata     (bus_wdata),
        .load_mask (load_mask),
        .load_val  (load_val),
        .clr_mask  (clr_mask)
    );

    always_comb begin
        r_d     = r_q;
        r_d.st  = (r_q.st & ~load_mask) | (load_val & load_mask);
        r_d.st  = r_d.st & ~clr_mask;
        r_d.st  = (r_d.st | hw_set) & ~hw_clr;
        r_d.chg = wr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = (bus_rd && hit) ? view : '0;
    assign hstate    = r_q.st;
    assign state_chg = r_q.chg;

endmodule

// File: rtl/shs_bank_chk.sv
module shs_bank_chk
    import shs_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFS = 'hD24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic               bus_sec,
    input logic [REG_W-1:0]   bus_rdata,
    input logic               route_ns,
    input logic [NSTATE-1:0]  hw_set,
    input logic [NSTATE-1:0]  hw_clr,
    input logic [NSTATE-1:0]  hstate,
    input logic               state_chg
);

    localparam logic [REG_W-1:0] RSVD = 32'hFFC0_0240;

    logic at_reg;
    logic hw_any;
    assign at_reg = (bus_addr == REG_OFS);
    assign hw_any = |(hw_set | hw_clr);

    AST_CHG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_reg) |=> state_chg); // R10
    AST_CHG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && at_reg) |=> !state_chg); // R10
    AST_SEC_HF_ACT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sec && !hw_any) |=> $stable(hstate[13])); // R6
    AST_NS_SF_WI: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sec && !hw_any) |=> $stable(hstate[29:27])); // R3
    AST_NS_SF_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sec) |-> (bus_rdata[4] == 1'b0 && bus_rdata[19] == 1'b0 && bus_rdata[20] == 1'b0)); // R3
    AST_BF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sec && !route_ns && !hw_any) |=> $stable(hstate[26:24])); // R4
    AST_NMI_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_set[30] |=> !$rose(hstate[30])); // R7
    AST_NS_HF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_set[1] |=> !$rose(hstate[1])); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> ((bus_rdata & RSVD) == '0)); // R11
    AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !at_reg) |-> (bus_rdata == '0)); // R11
    AST_HW_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_clr) |=> ((hstate & $past(hw_clr)) == '0)); // R12

endmodule

bind shs_bank_reg shs_bank_chk #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_sec   (bus_sec),
    .bus_rdata (bus_rdata),
    .route_ns  (route_ns),
    .hw_set    (hw_set),
    .hw_clr    (hw_clr),
    .hstate    (hstate),
    .state_chg (state_chg)
);

// File: tb/tb_shs_bank_reg.sv
module tb_shs_bank_reg;

    localparam logic [11:0] OFS = 12'hD24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sec = 1'b0;
    logic        cpu_sec = 1'b0, route_ns = 1'b0;
    logic [31:0] hw_set = '0, hw_clr = '0;
    logic [31:0] rd0, rd1, hs0, hs1;
    logic        chg0, chg1;

    int    nvec = 0;
    int    nfail = 0;
    bit    done = 0;
    string req = "R1";

    logic [31:0] m_st [2];
    logic        m_chg;

    int bpos [12] = '{0, 2, 3, 7, 10, 11, 12, 13, 15, 21, 16, 18};

    always #2 clk = ~clk;

    shs_bank_reg #(.ADDR_W(12), .REG_OFS(OFS), .LEGACY(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sec(bus_sec), .bus_rdata(rd0),
        .cpu_sec(cpu_sec), .route_ns(route_ns), .hw_set(hw_set), .hw_clr(hw_clr),
        .hstate(hs0), .state_chg(chg0));

    shs_bank_reg #(.ADDR_W(12), .REG_OFS(OFS), .LEGACY(1'b1)) dut_leg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sec(bus_sec), .bus_rdata(rd1),
        .cpu_sec(cpu_sec), .route_ns(route_ns), .hw_set(hw_set), .hw_clr(hw_clr),
        .hstate(hs1), .state_chg(chg1));

    // expected register view of a model state
    function automatic logic [31:0] m_read(logic [31:0] s, bit sec, bit rt, bit leg);
        logic [31:0] v = '0;
        for (int k = 0; k < 12; k++) begin
            if (sec) v[bpos[k]] = s[12 + k];
            else if (!(leg && (k == 1 || k == 9))) v[bpos[k]] = s[k];
        end
        if (sec) begin
            v[4] = s[27]; v[20] = s[28]; v[19] = s[29];
        end
        if (sec || rt) begin
            v[1] = s[24]; v[14] = s[25]; v[17] = s[26];
            if (!leg) v[5] = s[30];
        end
        v[8] = s[31];
        return v;
    endfunction

    function automatic logic [31:0] m_write(logic [31:0] s, logic [31:0] w, bit sec,
                                            bit rt, bit cs, bit leg);
        logic [31:0] n = s;
        for (int k = 0; k < 12; k++) begin
            if (k == 1) continue;
            if (sec) n[12 + k] = w[bpos[k]];
            else if (!(leg && k == 9)) n[k] = w[bpos[k]];
        end
        if (sec) begin
            n[27] = w[4]; n[28] = w[20]; n[29] = w[19];
        end
        if (sec || rt) begin
            n[24] = w[1]; n[25] = w[14]; n[26] = w[17];
        end
        if (!sec && cs && rt) begin
            if (!w[5]) n[30] = 1'b0;
            if (!w[2]) n[1]  = 1'b0;
        end
        n[31] = w[8];
        return n;
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        bit hit;
        #1;
        hit = (bus_addr == OFS);
        chk("rdata", rd0, (bus_rd && hit) ? m_read(m_st[0], bus_sec, route_ns, 0) : '0);
        chk("rdata_leg", rd1, (bus_rd && hit) ? m_read(m_st[1], bus_sec, route_ns, 1) : '0);
        chk("hstate", hs0, m_st[0]);
        chk("hstate_leg", hs1, m_st[1]);
        chk("chg", {31'd0, chg0}, {31'd0, m_chg});
        chk("chg_leg", {31'd0, chg1}, {31'd0, m_chg});
        @(posedge clk);
        if (!rst_n) begin
            m_st[0] = '0; m_st[1] = '0; m_chg = 1'b0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (bus_wr && hit)
                    m_st[i] = m_write(m_st[i], bus_wdata, bus_sec, route_ns, cpu_sec, i == 1);
                m_st[i] = (m_st[i] | hw_set) & ~hw_clr;
            end
            m_chg = bus_wr && hit;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; hw_set = '0; hw_clr = '0; bus_addr = OFS;
        tick();
    endtask

    task automatic wr(bit sec, logic [31:0] d);
        bus_addr = OFS; bus_wr = 1; bus_rd = 0; bus_sec = sec; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(bit sec);
        bus_addr = OFS; bus_wr = 0; bus_rd = 1; bus_sec = sec;
        tick();
        bus_rd = 0;
    endtask

    task automatic rd_both();
        rd(1'b1);
        rd(1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        m_st[0] = '0; m_st[1] = '0; m_chg = 1'b0;
        @(negedge clk);

        req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        idle();
        rd_both();

        req = "R2";
        route_ns = 0;
        wr(1'b1, 32'hFFFF_FFFF);
        rd_both();
        wr(1'b0, 32'h0005_3489);
        rd_both();
        wr(1'b1, 32'h0000_0000);
        rd_both();

        req = "R3";
        wr(1'b0, 32'hFFFF_FFFF);
        rd_both();
        wr(1'b1, 32'h0018_0010);
        wr(1'b0, 32'h0000_0000);
        rd_both();

        req = "R4";
        route_ns = 0;
        wr(1'b0, 32'h0002_4002);
        rd_both();
        route_ns = 1;
        wr(1'b0, 32'h0002_4002);
        rd_both();
        route_ns = 0;
        rd_both();
        wr(1'b0, 32'h0000_0000);
        route_ns = 1;
        rd(1'b0);

        req = "R5";
        hw_set = 32'h4000_0000; idle();
        route_ns = 0; rd_both();
        route_ns = 1; rd_both();

        req = "R6";
        hw_set = 32'h0000_2000; idle();
        wr(1'b1, 32'h0000_0000);
        rd(1'b1);
        wr(1'b1, 32'hFFFF_FFFF);
        hw_clr = 32'h0000_2000; idle();
        wr(1'b1, 32'h0000_0004);
        rd(1'b1);

        req = "R7";
        hw_set = 32'h4000_0002; idle();
        cpu_sec = 0; route_ns = 1; wr(1'b0, 32'h0000_0000);
        cpu_sec = 1; route_ns = 0; wr(1'b0, 32'h0000_0000);
        route_ns = 1; wr(1'b1, 32'h0000_0000);
        wr(1'b0, 32'h0000_0024);
        rd_both();
        wr(1'b0, 32'h0000_0000);
        rd_both();
        wr(1'b0, 32'h0000_0024);
        rd_both();
        cpu_sec = 0;

        req = "R8";
        hw_set = 32'h0000_0202; idle();
        rd(1'b0);
        wr(1'b0, 32'h0000_0000);
        wr(1'b0, 32'h0020_0000);
        rd(1'b0);

        req = "R9";
        wr(1'b0, 32'h0000_0100);
        rd(1'b1);
        wr(1'b1, 32'h0000_0000);
        rd(1'b0);

        req = "R10";
        rd(1'b1);
        idle();
        wr(1'b1, 32'h0000_0001);
        idle();

        req = "R11";
        bus_addr = OFS + 12'd4; bus_wr = 1; bus_sec = 1; bus_wdata = 32'hFFFF_FFFF; tick();
        bus_wr = 0; bus_rd = 1; tick();
        bus_addr = OFS - 12'd4; bus_sec = 0; tick();
        bus_rd = 0;
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1);

        req = "R12";
        hw_clr = 32'h0000_1001; bus_addr = OFS; bus_wr = 1; bus_sec = 1;
        bus_wdata = 32'hFFFF_FFFF; tick();
        hw_clr = '0; hw_set = 32'h0000_0800; bus_wdata = 32'h0; tick();
        hw_set = 32'h8000_0001; hw_clr = 32'h8000_0001; bus_wdata = 32'hFFFF_FFFF; tick();
        idle();
        rd_both();

        req = "R2";
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            bus_addr  = lfsr[3] ? OFS : (lfsr[4] ? OFS + 12'd4 : OFS);
            bus_wr    = lfsr[5];
            bus_rd    = lfsr[6];
            bus_sec   = lfsr[7];
            cpu_sec   = lfsr[8];
            route_ns  = lfsr[9];
            bus_wdata = {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_A5A5;
            hw_set    = lfsr[10] ? (32'h1 << lfsr[15:11]) : '0;
            hw_clr    = lfsr[16] ? (32'h1 << lfsr[21:17]) : '0;
            tick();
        end
        idle();
        rd_both();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule